// File: doc/BRIEF.md
# Half-Duplex MAC Transmit Controller

This block drives the transmit side of one half-duplex MII port. It advances one nibble per clock cycle, so one cycle is four bit times. When the frame source raises a request, the controller waits for the channel to go quiet. It then sends the preamble and start delimiter, followed by the frame nibbles pulled from a buffer. The FCS arrives as the last nibbles of the buffered frame.

When a collision occurs, the controller sends a jam and tells the buffer to rewind. It then waits a truncated binary exponential backoff before trying again. After too many consecutive collisions it either starts a fresh attempt cycle or discards the frame, depending on a per-port option. Collisions that arrive deep into a frame are reported separately but are still retried.

All timing is in nibble cycles: the gap is 24 cycles (96 bit times), the slot is 128 cycles (512 bit times) and the jam is 8 cycles (32 bits). Frame bytes are presented low nibble first. The nibble index of a transmission counts from 0 at the first preamble nibble.

Top module: `mac_hd_tx`

## Requirements
- R1: While reset is asserted and right after it, txen_o, txd_o, rd_o, done_o, retry_o, exc_col_o and late_col_o are all 0.
- R2: With carrier low, TXEN rises exactly 25 cycles after the first cycle in which tx_req_i is seen high while idle. This gives 16 silent cycles plus 8 wait cycles, and TXEN never rises for a preamble with fewer than 24 low cycles before it.
- R3: Carrier during the 16-cycle silence window restarts that window: TXEN rises 25 cycles after the last cycle in which crs_i was high.
- R4: Carrier during the 8-cycle wait that follows the silence makes the controller transmit jam (txd_o = 4'h9) with txen_o high for 8 cycles, starting the next cycle. This counts as a collision, so retry_o pulses in the cycle after the jam.
- R5: A transmission is 15 nibbles of 4'h5, one nibble of 4'hD, then every frame nibble in order. rd_o is high exactly on the frame nibbles. In the cycle after the nibble flagged frm_last_i, txen_o is low and done_o pulses for one cycle.
- R6: col_i seen during preamble or frame nibbles ends the frame. The next 8 cycles carry jam (4'h9) with txen_o high, and in the following cycle txen_o is low and retry_o pulses.
- R7: After the n-th consecutive collision (n below 16), TXEN rises again r*128+25 cycles after the retry_o cycle. Here r is rand_i masked to its low min(n,10) bits, sampled on the last jam cycle.
- R8: late_col_o pulses together with the retry report when the collision is seen at a nibble index above 128. At index 128 or below it stays low.
- R9: On the 16th consecutive collision with drop_exc_i low, exc_col_o and retry_o pulse together. The attempt count restarts, TXEN rises 24 cycles after that pulse with no backoff, and the next collision draws from 1 random bit.
- R10: On the 16th consecutive collision with drop_exc_i high, exc_col_o and done_o pulse together, retry_o stays low and nothing more is transmitted for the frame.
- R11: col_i outside a transmission has no effect: it produces no pulse and does not change when TXEN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Nibble clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_req_i | input | 1 | Frame ready; held until done_o |
| frm_nib_i | input | 4 | Current frame nibble from the buffer |
| frm_last_i | input | 1 | Current nibble is the last of the frame |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detect |
| drop_exc_i | input | 1 | Discard the frame after 16 collisions |
| rand_i | input | 10 | Pseudo-random source for backoff |
| txen_o | output | 1 | Transmit enable |
| txd_o | output | 4 | Transmit nibble |
| rd_o | output | 1 | Buffer read strobe, advances the buffer |
| done_o | output | 1 | Frame sent or discarded |
| retry_o | output | 1 | Attempt aborted; buffer rewinds to frame start |
| exc_col_o | output | 1 | Excessive collision pulse |
| late_col_o | output | 1 | Late collision pulse |

## Verification
The hardest state to reach is the 16th consecutive collision. Getting there takes sixteen full defer, preamble and jam rounds, each of which would normally include a random backoff. The stimulus holds rand_i at zero so every backoff lasts one cycle. It injects a one-cycle col_i at preamble nibble 2 on each attempt, then switches rand_i to all ones after the restart to show that exactly one random bit is used. The late-collision boundary is reached with a 200-nibble frame and collisions placed at nibble indices 128 and 129.

// File: rtl/mhtx_pkg.sv
package mhtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEFER, ST_WAIT, ST_PRE, ST_DATA, ST_JAM, ST_BACKOFF
  } tx_state_e;

  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;
  localparam logic [3:0] JAM_NIB_PAT = 4'h9;
endpackage

// File: rtl/mhtx_backoff.sv
module mhtx_backoff #(
  parameter int unsigned CAP      = 10,
  parameter int unsigned SLOT_NIB = 128,
  localparam int unsigned KW = $clog2(CAP + 1),
  localparam int unsigned SW = $clog2(SLOT_NIB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [KW-1:0]  k_i,
  input  logic [CAP-1:0] rand_i,
  output logic           idle_o
);
  logic [CAP-1:0] mask;
  logic [CAP-1:0] slots_q;
  logic [SW-1:0]  nib_q;

  always_comb mask = ~({CAP{1'b1}} << k_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      nib_q   <= '0;
    end else if (start_i) begin
      slots_q <= rand_i & mask;
      nib_q   <= '0;
    end else if (slots_q != '0) begin
      if (nib_q == SW'(SLOT_NIB - 1)) begin
        nib_q   <= '0;
        slots_q <= slots_q - 1'b1;
      end else begin
        nib_q <= nib_q + 1'b1;
      end
    end
  end

  assign idle_o = (slots_q == '0);
endmodule

// File: rtl/mhtx_attempts.sv
module mhtx_attempts #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned CAP   = 10,
  localparam int unsigned AW = $clog2(LIMIT + 1),
  localparam int unsigned KW = $clog2(CAP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic          at_limit_o,
  output logic [KW-1:0] k_o
);
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] nxt;

  always_comb begin
    nxt        = cnt_q + 1'b1;
    at_limit_o = (nxt == AW'(LIMIT));
    k_o        = (nxt > AW'(CAP)) ? KW'(CAP) : KW'(nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= nxt;
  end
endmodule

// File: rtl/mhtx_nibsel.sv
module mhtx_nibsel
  import mhtx_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRE_NIBS = 16,
  parameter logic [3:0]  JAM_PAT  = JAM_NIB_PAT
) (
  input  tx_state_e        state_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [3:0]       frm_nib_i,
  output logic             txen_o,
  output logic [3:0]       txd_o,
  output logic             rd_o
);
  always_comb begin
    txen_o = 1'b0;
    txd_o  = '0;
    rd_o   = 1'b0;
    unique case (state_i)
      ST_PRE: begin
        txen_o = 1'b1;
        txd_o  = (idx_i == CNT_W'(PRE_NIBS - 1)) ? SFD_NIB : PRE_NIB;
      end
      ST_DATA: begin
        txen_o = 1'b1;
        txd_o  = frm_nib_i;
        rd_o   = 1'b1;
      end
      ST_JAM: begin
        txen_o = 1'b1;
        txd_o  = JAM_PAT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_hd_tx.sv
module mac_hd_tx
  import mhtx_pkg::*;
#(
  parameter int unsigned DEFER_NIB     = 16,
  parameter int unsigned WAIT_NIB      = 8,
  parameter int unsigned PRE_NIBS      = 16,
  parameter int unsigned JAM_NIB       = 8,
  parameter int unsigned SLOT_NIB      = 128,
  parameter int unsigned ATTEMPT_LIMIT = 16,
  parameter int unsigned BACKOFF_CAP   = 10,
  parameter int unsigned CNT_W         = 16,
  parameter logic [3:0]  JAM_PAT       = JAM_NIB_PAT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tx_req_i,
  input  logic [3:0]             frm_nib_i,
  input  logic                   frm_last_i,
  input  logic                   crs_i,
  input  logic                   col_i,
  input  logic                   drop_exc_i,
  input  logic [BACKOFF_CAP-1:0] rand_i,
  output logic                   txen_o,
  output logic [3:0]             txd_o,
  output logic                   rd_o,
  output logic                   done_o,
  output logic                   retry_o,
  output logic                   exc_col_o,
  output logic                   late_col_o
);
  localparam int unsigned KW = $clog2(BACKOFF_CAP + 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             late_q, late_d;
  logic             done_d, retry_d, exc_d, latep_d;
  logic             att_inc, att_clr, at_limit, bo_start, bo_idle;
  logic [KW-1:0]    bo_k;

  mhtx_attempts #(.LIMIT(ATTEMPT_LIMIT), .CAP(BACKOFF_CAP)) u_att (
    .clk_i, .rst_ni, .inc_i(att_inc), .clr_i(att_clr),
    .at_limit_o(at_limit), .k_o(bo_k)
  );

  mhtx_backoff #(.CAP(BACKOFF_CAP), .SLOT_NIB(SLOT_NIB)) u_bo (
    .clk_i, .rst_ni, .start_i(bo_start), .k_i(bo_k), .rand_i,
    .idle_o(bo_idle)
  );

  mhtx_nibsel #(.CNT_W(CNT_W), .PRE_NIBS(PRE_NIBS), .JAM_PAT(JAM_PAT)) u_sel (
    .state_i(state_q), .idx_i(cnt_q), .frm_nib_i,
    .txen_o, .txd_o, .rd_o
  );

  // saturating so very long frames keep a valid "late" verdict
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    late_d   = late_q;
    done_d   = 1'b0;
    retry_d  = 1'b0;
    exc_d    = 1'b0;
    latep_d  = 1'b0;
    att_inc  = 1'b0;
    att_clr  = 1'b0;
    bo_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (tx_req_i) begin
        state_d = ST_DEFER;
        cnt_d   = '0;
      end
      ST_DEFER: begin
        if (crs_i) cnt_d = '0;
        else if (cnt_q == CNT_W'(DEFER_NIB - 1)) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else cnt_d = cnt_inc;
      end
      ST_WAIT: begin
        if (crs_i) begin
          // carrier too late to defer: force the collision
          state_d = ST_JAM;
          cnt_d   = '0;
          late_d  = 1'b0;
        end else if (cnt_q == CNT_W'(WAIT_NIB - 1)) begin
          state_d = ST_PRE;
          cnt_d   = '0;
        end else cnt_d = cnt_inc;
      end
      ST_PRE, ST_DATA: begin
        if (col_i) begin
          state_d = ST_JAM;
          cnt_d   = '0;
          late_d  = (cnt_q > CNT_W'(SLOT_NIB));
        end else if (state_q == ST_DATA && frm_last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          att_clr = 1'b1;
        end else begin
          cnt_d = cnt_inc;
          if (cnt_q == CNT_W'(PRE_NIBS - 1)) state_d = ST_DATA;
        end
      end
      ST_JAM: begin
        if (cnt_q == CNT_W'(JAM_NIB - 1)) begin
          cnt_d   = '0;
          latep_d = late_q;
          if (at_limit) begin
            exc_d   = 1'b1;
            att_clr = 1'b1;
            if (drop_exc_i) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              retry_d = 1'b1;
              state_d = ST_DEFER;
            end
          end else begin
            att_inc  = 1'b1;
            retry_d  = 1'b1;
            bo_start = 1'b1;
            state_d  = ST_BACKOFF;
          end
        end else cnt_d = cnt_inc;
      end
      ST_BACKOFF: if (bo_idle) begin
        state_d = ST_DEFER;
        cnt_d   = '0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      late_q     <= 1'b0;
      done_o     <= 1'b0;
      retry_o    <= 1'b0;
      exc_col_o  <= 1'b0;
      late_col_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      late_q     <= late_d;
      done_o     <= done_d;
      retry_o    <= retry_d;
      exc_col_o  <= exc_d;
      late_col_o <= latep_d;
    end
  end
endmodule

// File: rtl/mac_hd_tx_chk.sv
module mac_hd_tx_chk
  import mhtx_pkg::*;
#(
  parameter int unsigned IFG_NIB = 24,
  parameter logic [3:0]  JAM_PAT = JAM_NIB_PAT,
  parameter int unsigned GW      = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       col_i,
  input logic       txen_o,
  input logic [3:0] txd_o,
  input logic       rd_o,
  input logic       done_o,
  input logic       retry_o,
  input logic       exc_col_o,
  input logic       late_col_o
);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= '0;
    else if (txen_o)   gap_q <= '0;
    else if (~&gap_q)  gap_q <= gap_q + 1'b1;
  end

  AST_IFG_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(txen_o) && txd_o != JAM_PAT) |-> gap_q >= GW'(IFG_NIB)); // R2
  AST_COL_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && col_i) |=> (txen_o && !rd_o && txd_o == JAM_PAT)); // R6
  AST_REPORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o || done_o) |-> !txen_o); // R6
  AST_LATE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_col_o |-> (retry_o || done_o)); // R8
  AST_EXC_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_col_o |-> (retry_o || done_o)); // R9
  AST_DONE_NO_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !retry_o); // R10
endmodule

bind mac_hd_tx mac_hd_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_i(col_i), .txen_o(txen_o),
  .txd_o(txd_o), .rd_o(rd_o), .done_o(done_o), .retry_o(retry_o),
  .exc_col_o(exc_col_o), .late_col_o(late_col_o)
);

// File: tb/mac_hd_tx_tb.sv
module mac_hd_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int JAM = 9;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_req = 1'b0, crs = 1'b0, col = 1'b0, drop = 1'b0;
  logic [9:0] rnd = '0;
  logic [3:0] frm_nib;
  logic       frm_last;
  logic       txen, rd, done, retry, exc, late;
  logic [3:0] txd;

  logic [3:0] buf_mem [0:255];
  int buf_len = 1;
  int ptr = 0;
  int checks = 0, fails = 0, cyc = 0;

  assign frm_nib  = buf_mem[ptr[7:0]];
  assign frm_last = (ptr == buf_len - 1);

  mac_hd_tx u_dut (
    .clk_i(clk), .rst_ni, .tx_req_i(tx_req), .frm_nib_i(frm_nib),
    .frm_last_i(frm_last), .crs_i(crs), .col_i(col), .drop_exc_i(drop),
    .rand_i(rnd), .txen_o(txen), .txd_o(txd), .rd_o(rd), .done_o(done),
    .retry_o(retry), .exc_col_o(exc), .late_col_o(late)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (retry) ptr <= 0;
    else if (rd) ptr <= ptr + 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic load_frame(input int len);
    for (int j = 0; j < len; j++) buf_mem[j] = 4'((j * 5 + 1) ^ (j >> 4));
    buf_len = len;
    ptr = 0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!txen && n < 5000);
  endtask

  // entered at the negedge of nibble index 0
  task automatic check_frame(input string req);
    int errs = 0;
    for (int i = 0; i < 16; i++) begin
      if (!txen || rd || txd != ((i == 15) ? 4'hD : 4'h5)) errs++;
      @(negedge clk);
    end
    for (int j = 0; j < buf_len; j++) begin
      if (!txen || !rd || txd != buf_mem[j]) errs++;
      @(negedge clk);
    end
    chk({req, " nibbles"}, errs, 0);
    chk({req, " done"}, {txen, done, retry}, 3'b010);
  endtask

  task automatic check_jam(input string req);
    int errs = 0;
    for (int k = 0; k < 8; k++) begin
      if (!txen || rd || txd != 4'(JAM)) errs++;
      @(negedge clk);
    end
    chk({req, " jam"}, errs, 0);
  endtask

  task automatic collide(input int n);
    repeat (n) @(negedge clk);
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    check_jam("R6");
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {txen, txd, rd, done, retry, exc, late}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", {txen, txd, rd, done, retry, exc, late}, 0);
  endtask

  task automatic t_basic;
    int n;
    load_frame(20);
    tx_req = 1'b1;
    wait_rise(n);
    chk("R2 start delay", n, 25);
    check_frame("R5");
    tx_req = 1'b0;
    @(negedge clk);
    chk("R5 single done", done, 0);
  endtask

  task automatic t_defer_crs;
    int n;
    load_frame(12);
    tx_req = 1'b1;
    repeat (5) @(negedge clk);
    crs = 1'b1; col = 1'b1;  // R11: col while deferring
    repeat (3) @(negedge clk);
    crs = 1'b0; col = 1'b0;
    chk("R11 no pulse", {retry, exc, late, done}, 0);
    wait_rise(n);
    chk("R3 restart", n, 24);
    check_frame("R11");
    tx_req = 1'b0;
  endtask

  task automatic t_wait_crs;
    int n;
    rnd = '0;
    load_frame(8);
    tx_req = 1'b1;
    repeat (19) @(negedge clk);
    crs = 1'b1;
    @(negedge clk);
    crs = 1'b0;
    check_jam("R4");
    chk("R4 retry", {retry, txen}, 2'b10);
    wait_rise(n);
    chk("R4 resend", n, 25);
    check_frame("R4");
    tx_req = 1'b0;
  endtask

  task automatic t_backoff;
    int n;
    rnd = '1;
    load_frame(20);
    tx_req = 1'b1;
    wait_rise(n);
    collide(3);
    chk("R6 retry no late", {retry, late, exc}, 3'b100);
    wait_rise(n);
    chk("R7 one bit", n, 128 + 25);
    collide(3);
    wait_rise(n);
    chk("R7 two bits", n, 3 * 128 + 25);
    check_frame("R7");
    tx_req = 1'b0;
    rnd = '0;
  endtask

  task automatic t_late;
    int n;
    load_frame(200);
    tx_req = 1'b1;
    wait_rise(n);
    collide(128);
    chk("R8 index 128", {retry, late}, 2'b10);
    wait_rise(n);
    collide(129);
    chk("R8 index 129", {retry, late}, 2'b11);
    wait_rise(n);
    chk("R8 still retried", n, 25);
    check_frame("R8");
    tx_req = 1'b0;
  endtask

  task automatic t_excessive;
    int n;
    int errs = 0;
    load_frame(10);
    tx_req = 1'b1;
    wait_rise(n);
    for (int a = 1; a <= 16; a++) begin
      collide(2);
      if (a < 16 && {retry, exc, done} != 3'b100) errs++;
      if (a == 16) chk("R9 limit pulse", {retry, exc, done}, 3'b110);
      wait_rise(n);
      if (a < 16 && n != 25) errs++;
      if (a == 16) chk("R9 gap only", n, 24);
    end
    chk("R9 rounds 1..15", errs, 0);
    rnd = '1;
    collide(2);
    chk("R9 restarted", {retry, exc}, 2'b10);
    wait_rise(n);
    chk("R9 k back to 1", n, 128 + 25);
    rnd = '0;
    check_frame("R9");
    tx_req = 1'b0;
  endtask

  task automatic t_drop;
    int n;
    int seen = 0;
    drop = 1'b1;
    load_frame(10);
    tx_req = 1'b1;
    wait_rise(n);
    for (int a = 1; a <= 16; a++) begin
      collide(2);
      if (a < 16) wait_rise(n);
    end
    chk("R10 drop pulse", {done, exc, retry}, 3'b110);
    tx_req = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (txen || retry) seen++;
    end
    chk("R10 silent", seen, 0);
    drop = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_defer_crs();
    t_wait_crs();
    t_backoff();
    t_late();
    t_excessive();
    t_drop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule